// File: doc/BRIEF.md
# Address Translation Sequencer with Fault Syndrome

This block takes one memory access request at a time and decides how its effective address becomes a real address, or why it cannot. It checks the conditions in a fixed order. A real-mode bypass comes first. Next comes the answer of an external block-translation matcher, then the selection of one of sixteen segment registers, the direct-store rules and the segment no-execute check. Last come the answer of an external page-table walker and the key/PP permission decode. The matcher and the walker sit outside this block and are reached through simple request/response ports.

Every request ends with a single-cycle `done_o` pulse. The pulse carries either a real address with read/write/execute permissions, or an exception class with a 32-bit status syndrome. Data-side faults also update a fault-address register. After a successful page translation that was not a write, write permission is removed from the result, so that a later store translates again and the changed bit can be set.

Top module: `xlat_seq`

## Requirements
- R1: A fetch (`acc_i`=2) with `ir_en_i`=0, or a read/write (`acc_i`=0/1) with `dr_en_i`=0, completes on the clock edge that accepts it. It returns `pa_o`=`ea_i` and `prot_o`=3'b111, and issues no block or walk request.
- R2: Otherwise a block lookup is issued first. On a block hit, `pa_o` and `prot_o` come from the matcher unchanged and no walk is issued, even in a direct-store segment. If the hit lacks the needed right, a protection fault results. The needed right is read for acc 0, write for acc 1 and execute for acc 2, and `prot_o` bit 0 is read, bit 1 write, bit 2 execute.
- R3: On a block miss, the segment register is taken from `seg_regs_i` slice `ea[31:28]` (32 bits each). A walk is then issued with `walk_vsid_o` = segment bits 23:0 and `walk_ea_o` = the request address. A found page yields `pa_o` = {`walk_rpn_i`, ea[11:0]}.
- R4: The key is segment bit 29 in user mode and bit 30 in supervisor mode. With key 0, PP values 0, 1 and 2 grant read and write, and PP 3 grants read only. With key 1, PP 0 grants nothing, PP 1 and PP 3 grant read, and PP 2 grants read and write.
- R5: Segment bit 28 (no-execute) removes execute from page results. A fetch from such a segment faults without any walk.
- R6: When segment bit 31 (direct store) is set and bits 28:20 equal 9'h07F, the result is `pa_o` = {segment bits 3:0, ea[27:0]} with `prot_o`=3'b111, for any access kind or class.
- R7: In any other direct-store segment, a fetch faults. Class `cls_i` 0 (integer) and class 3 (cache management) pass `pa_o`=ea with `prot_o`=3'b011. Class 1 (floating point) raises an alignment exception with syndrome 0. Class 2 (reservation) and class 4 (external control) raise data faults.
- R8: Fetch faults report `exc_o`=1 with syndrome 32'h40000000 for no page, 32'h08000000 for protection, and 32'h10000000 for no-execute or direct-store.
- R9: Data faults report `exc_o`=2 with syndrome 32'h40000000 for no page and 32'h08000000 for protection. A reservation direct-store fault gives 32'h04000000 and an external-control one gives 32'h04100000. Each of these has 32'h02000000 added on writes.
- R10: `far_o` takes the request address on every data or alignment fault (`exc_o` 2 or 3) and holds otherwise. It resets to 0.
- R11: A successful page-walk result for a read or fetch has `prot_o` bit 1 cleared. A write keeps it.
- R12: `exc_o` encodes 0 none, 1 instruction fault, 2 data fault, 3 alignment. Faults return `pa_o`=0 and `prot_o`=0, and successes return syndrome 0. Each accepted request gives exactly one single-cycle `done_o`, and a `req_i` raised while a request is in progress is ignored. After reset, `done_o`, `exc_o`, `far_o` and both request outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Start a translation (taken only when idle) |
| ea_i | input | 32 | Effective address |
| acc_i | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| cls_i | input | 3 | Access class: 0 int, 1 float, 2 reservation, 3 cache, 4 external |
| user_i | input | 1 | User (problem) state |
| ir_en_i | input | 1 | Instruction translation enable |
| dr_en_i | input | 1 | Data translation enable |
| seg_regs_i | input | 512 | Sixteen 32-bit segment registers, register n at bits 32n+31:32n |
| blk_req_o | output | 1 | Block lookup request (held until response) |
| blk_ea_o | output | 32 | Address for block lookup |
| blk_fetch_o | output | 1 | Block lookup is for a fetch |
| blk_rsp_i | input | 1 | Block lookup response strobe |
| blk_hit_i | input | 1 | Block lookup hit |
| blk_pa_i | input | 32 | Block real address |
| blk_prot_i | input | 3 | Block permissions {x,w,r} |
| walk_req_o | output | 1 | Page walk request (held until response) |
| walk_ea_o | output | 32 | Address for the walk |
| walk_vsid_o | output | 24 | Virtual segment ID for the walk |
| walk_rsp_i | input | 1 | Walk response strobe |
| walk_found_i | input | 1 | Page found |
| walk_pp_i | input | 2 | Page protection field |
| walk_rpn_i | input | 20 | Real page number |
| done_o | output | 1 | One-cycle completion pulse |
| pa_o | output | 32 | Real address |
| prot_o | output | 3 | Granted permissions {x,w,r} |
| exc_o | output | 2 | Exception class |
| syn_o | output | 32 | Fault syndrome |
| far_o | output | 32 | Fault address of last data-side fault |

## Verification
A wrong check order shows up at the ports at once. A fetch from a no-execute segment would reach the walker, and a direct-store access would be answered in place of a block hit. A bad segment snapshot or key selection shows up in the `done_o` cycle, one or more cycles after the walk response, as a wrong `walk_vsid_o` or a wrong permission or syndrome. A corrupt state register shows up within the same request as a missing, repeated or extra `done_o`, or as a `far_o` that moves on a success or on an instruction fault.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  localparam int SR_W = 32;

  // segment register fields
  localparam int SEG_T     = 31;
  localparam int SEG_KS    = 30;
  localparam int SEG_KP    = 29;
  localparam int SEG_NX    = 28;
  localparam int DS_UNIT_LSB = 20;
  localparam int DS_UNIT_W   = 9;
  localparam logic [DS_UNIT_W-1:0] DS_OPEN_UNIT = 9'h07F;

  localparam logic [1:0] ACC_RD = 2'd0;
  localparam logic [1:0] ACC_WR = 2'd1;
  localparam logic [1:0] ACC_FX = 2'd2;

  localparam logic [2:0] CLS_INT   = 3'd0;
  localparam logic [2:0] CLS_FLOAT = 3'd1;
  localparam logic [2:0] CLS_RES   = 3'd2;
  localparam logic [2:0] CLS_CACHE = 3'd3;
  localparam logic [2:0] CLS_EXT   = 3'd4;

  localparam logic [2:0] PR_R = 3'b001;
  localparam logic [2:0] PR_W = 3'b010;
  localparam logic [2:0] PR_X = 3'b100;
  localparam logic [2:0] PR_ALL = 3'b111;

  localparam logic [31:0] SYN_NOPAGE = 32'h4000_0000;
  localparam logic [31:0] SYN_PROT   = 32'h0800_0000;
  localparam logic [31:0] SYN_NOEXEC = 32'h1000_0000;
  localparam logic [31:0] SYN_WRITE  = 32'h0200_0000;
  localparam logic [31:0] SYN_DSRES  = 32'h0400_0000;
  localparam logic [31:0] SYN_DSEXT  = 32'h0410_0000;

  typedef enum logic [1:0] {
    EXC_NONE  = 2'd0,
    EXC_INSN  = 2'd1,
    EXC_DATA  = 2'd2,
    EXC_ALIGN = 2'd3
  } exc_e;

  typedef enum logic [2:0] {
    F_NONE, F_NOPAGE, F_PROT, F_NOEXEC, F_DSTORE
  } fault_e;

  typedef enum logic [1:0] {
    S_IDLE, S_BLK, S_WALK
  } state_e;

  function automatic logic [2:0] need_mask(input logic [1:0] acc);
    case (acc)
      ACC_WR:  need_mask = PR_W;
      ACC_FX:  need_mask = PR_X;
      default: need_mask = PR_R;
    endcase
  endfunction

endpackage

// File: rtl/xlat_perm.sv
module xlat_perm
  import xlat_pkg::*;
(
  input  logic       key_i,
  input  logic       nx_i,
  input  logic [1:0] pp_i,
  output logic [2:0] prot_o
);
  logic [2:0] rw;

  always_comb begin
    if (!key_i) begin
      rw = (pp_i == 2'd3) ? PR_R : (PR_R | PR_W);
    end else begin
      case (pp_i)
        2'd0:    rw = 3'b000;
        2'd2:    rw = PR_R | PR_W;
        default: rw = PR_R;
      endcase
    end
    prot_o = rw | (nx_i ? 3'b000 : PR_X);
  end
endmodule

// File: rtl/xlat_dstore.sv
module xlat_dstore
  import xlat_pkg::*;
#(
  parameter int AW    = 32,
  parameter int SEL_W = 4
) (
  input  logic [DS_UNIT_W-1:0] unit_i,
  input  logic [SEL_W-1:0]     hi_i,
  input  logic [AW-1:0]        ea_i,
  input  logic [1:0]           acc_i,
  input  logic [2:0]           cls_i,
  output logic                 fault_o,
  output logic [AW-1:0]        pa_o,
  output logic [2:0]           prot_o
);
  logic open_unit;
  assign open_unit = (unit_i == DS_OPEN_UNIT);

  always_comb begin
    fault_o = 1'b0;
    pa_o    = ea_i;
    prot_o  = PR_R | PR_W;
    if (open_unit) begin
      pa_o   = {hi_i, ea_i[AW-SEL_W-1:0]};
      prot_o = PR_ALL;
    end else if (acc_i == ACC_FX) begin
      fault_o = 1'b1;
    end else if (cls_i != CLS_INT && cls_i != CLS_CACHE) begin
      fault_o = 1'b1;
    end
    if (fault_o) begin
      pa_o   = '0;
      prot_o = '0;
    end
  end
endmodule

// File: rtl/xlat_fault_enc.sv
module xlat_fault_enc
  import xlat_pkg::*;
(
  input  fault_e      kind_i,
  input  logic [1:0]  acc_i,
  input  logic [2:0]  cls_i,
  output exc_e        exc_o,
  output logic [31:0] syn_o
);
  logic [31:0] wbit;
  assign wbit = (acc_i == ACC_WR) ? SYN_WRITE : 32'h0;

  always_comb begin
    exc_o = EXC_NONE;
    syn_o = '0;
    if (kind_i != F_NONE) begin
      if (acc_i == ACC_FX) begin
        exc_o = EXC_INSN;
        case (kind_i)
          F_NOPAGE: syn_o = SYN_NOPAGE;
          F_PROT:   syn_o = SYN_PROT;
          default:  syn_o = SYN_NOEXEC;
        endcase
      end else begin
        exc_o = EXC_DATA;
        case (kind_i)
          F_NOPAGE: syn_o = SYN_NOPAGE | wbit;
          F_PROT:   syn_o = SYN_PROT | wbit;
          F_DSTORE: begin
            case (cls_i)
              CLS_FLOAT: exc_o = EXC_ALIGN;
              CLS_RES:   syn_o = SYN_DSRES | wbit;
              CLS_EXT:   syn_o = SYN_DSEXT | wbit;
              default:   syn_o = '0;
            endcase
          end
          default: syn_o = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/xlat_seq.sv
module xlat_seq
  import xlat_pkg::*;
#(
  parameter int AW      = 32,
  parameter int NSEG    = 16,
  parameter int VSID_W  = 24,
  parameter int PG_BITS = 12
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_i,
  input  logic [AW-1:0]        ea_i,
  input  logic [1:0]           acc_i,
  input  logic [2:0]           cls_i,
  input  logic                 user_i,
  input  logic                 ir_en_i,
  input  logic                 dr_en_i,
  input  logic [NSEG*SR_W-1:0] seg_regs_i,
  output logic                 blk_req_o,
  output logic [AW-1:0]        blk_ea_o,
  output logic                 blk_fetch_o,
  input  logic                 blk_rsp_i,
  input  logic                 blk_hit_i,
  input  logic [AW-1:0]        blk_pa_i,
  input  logic [2:0]           blk_prot_i,
  output logic                 walk_req_o,
  output logic [AW-1:0]        walk_ea_o,
  output logic [VSID_W-1:0]    walk_vsid_o,
  input  logic                 walk_rsp_i,
  input  logic                 walk_found_i,
  input  logic [1:0]           walk_pp_i,
  input  logic [AW-PG_BITS-1:0] walk_rpn_i,
  output logic                 done_o,
  output logic [AW-1:0]        pa_o,
  output logic [2:0]           prot_o,
  output logic [1:0]           exc_o,
  output logic [31:0]          syn_o,
  output logic [AW-1:0]        far_o
);
  localparam int SEL_W = $clog2(NSEG);

  typedef struct packed {
    logic              ks;
    logic              kp;
    logic              nx;
    logic [VSID_W-1:0] vsid;
  } seg_snap_t;

  state_e      state_q, state_d;
  logic [AW-1:0] ea_q;
  logic [1:0]  acc_q;
  logic [2:0]  cls_q;
  logic        user_q;
  seg_snap_t   seg_q;

  logic        done_q;
  logic [AW-1:0] pa_q, far_q;
  logic [2:0]  prot_q;
  exc_e        exc_q;
  logic [31:0] syn_q;

  // segment register file view
  logic [SR_W-1:0] seg_arr [NSEG];
  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    assign seg_arr[g] = seg_regs_i[g*SR_W +: SR_W];
  end

  logic [SR_W-1:0] seg_sel;
  assign seg_sel = seg_arr[ea_q[AW-1 -: SEL_W]];

  // direct-store rules
  logic          ds_fault;
  logic [AW-1:0] ds_pa;
  logic [2:0]    ds_prot;

  xlat_dstore #(.AW(AW), .SEL_W(SEL_W)) i_dstore (
    .unit_i  (seg_sel[DS_UNIT_LSB +: DS_UNIT_W]),
    .hi_i    (seg_sel[SEL_W-1:0]),
    .ea_i    (ea_q),
    .acc_i   (acc_q),
    .cls_i   (cls_q),
    .fault_o (ds_fault),
    .pa_o    (ds_pa),
    .prot_o  (ds_prot)
  );

  // page permission decode from snapshot
  logic [2:0] pg_prot;
  xlat_perm i_perm (
    .key_i  (user_q ? seg_q.kp : seg_q.ks),
    .nx_i   (seg_q.nx),
    .pp_i   (walk_pp_i),
    .prot_o (pg_prot)
  );

  logic [2:0] need;
  assign need = need_mask(acc_q);

  logic       bypass_in;
  assign bypass_in = (acc_i == ACC_FX) ? !ir_en_i : !dr_en_i;

  // sequencing
  logic          fin, ld_seg;
  fault_e        fkind;
  logic [AW-1:0] fpa;
  logic [2:0]    fprot;

  always_comb begin
    state_d = state_q;
    fin     = 1'b0;
    ld_seg  = 1'b0;
    fkind   = F_NONE;
    fpa     = '0;
    fprot   = '0;
    case (state_q)
      S_IDLE: begin
        if (req_i) begin
          if (bypass_in) begin
            fin   = 1'b1;
            fpa   = ea_i;
            fprot = PR_ALL;
          end else begin
            state_d = S_BLK;
          end
        end
      end
      S_BLK: begin
        if (blk_rsp_i) begin
          if (blk_hit_i) begin
            fin = 1'b1;
            if ((need & ~blk_prot_i) != 3'b000) begin
              fkind = F_PROT;
            end else begin
              fpa   = blk_pa_i;
              fprot = blk_prot_i;
            end
          end else if (seg_sel[SEG_T]) begin
            fin = 1'b1;
            if (ds_fault) begin
              fkind = F_DSTORE;
            end else begin
              fpa   = ds_pa;
              fprot = ds_prot;
            end
          end else if (acc_q == ACC_FX && seg_sel[SEG_NX]) begin
            fin   = 1'b1;
            fkind = F_NOEXEC;
          end else begin
            ld_seg  = 1'b1;
            state_d = S_WALK;
          end
        end
      end
      S_WALK: begin
        if (walk_rsp_i) begin
          fin = 1'b1;
          if (!walk_found_i) begin
            fkind = F_NOPAGE;
          end else if ((need & ~pg_prot) != 3'b000) begin
            fkind = F_PROT;
          end else begin
            fpa   = {walk_rpn_i, ea_q[PG_BITS-1:0]};
            // keep write off until a store comes through
            fprot = (acc_q == ACC_WR) ? pg_prot : (pg_prot & ~PR_W);
          end
        end
      end
      default: state_d = S_IDLE;
    endcase
    if (fin) state_d = S_IDLE;
  end

  exc_e        enc_exc;
  logic [31:0] enc_syn;

  xlat_fault_enc i_fenc (
    .kind_i (fkind),
    .acc_i  (acc_q),
    .cls_i  (cls_q),
    .exc_o  (enc_exc),
    .syn_o  (enc_syn)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      ea_q    <= '0;
      acc_q   <= ACC_RD;
      cls_q   <= CLS_INT;
      user_q  <= 1'b0;
      seg_q   <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == S_IDLE && req_i) begin
        ea_q   <= ea_i;
        acc_q  <= acc_i;
        cls_q  <= cls_i;
        user_q <= user_i;
      end
      if (ld_seg) begin
        seg_q.ks   <= seg_sel[SEG_KS];
        seg_q.kp   <= seg_sel[SEG_KP];
        seg_q.nx   <= seg_sel[SEG_NX];
        seg_q.vsid <= seg_sel[VSID_W-1:0];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      pa_q   <= '0;
      prot_q <= '0;
      exc_q  <= EXC_NONE;
      syn_q  <= '0;
      far_q  <= '0;
    end else begin
      done_q <= fin;
      if (fin) begin
        pa_q   <= fpa;
        prot_q <= fprot;
        exc_q  <= enc_exc;
        syn_q  <= enc_syn;
        if (enc_exc == EXC_DATA || enc_exc == EXC_ALIGN) far_q <= ea_q;
      end
    end
  end

  assign blk_req_o   = (state_q == S_BLK);
  assign blk_ea_o    = ea_q;
  assign blk_fetch_o = (acc_q == ACC_FX);
  assign walk_req_o  = (state_q == S_WALK);
  assign walk_ea_o   = ea_q;
  assign walk_vsid_o = seg_q.vsid;
  assign done_o      = done_q;
  assign pa_o        = pa_q;
  assign prot_o      = prot_q;
  assign exc_o       = exc_q;
  assign syn_o       = syn_q;
  assign far_o       = far_q;

endmodule

// File: rtl/xlat_seq_chk.sv
module xlat_seq_chk #(
  parameter int AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          blk_req_o,
  input logic          blk_rsp_i,
  input logic          blk_hit_i,
  input logic          walk_req_o,
  input logic          done_o,
  input logic [2:0]    prot_o,
  input logic [1:0]    exc_o,
  input logic [31:0]   syn_o,
  input logic [AW-1:0] far_o
);
  // R2
  walk_after_blk_miss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(walk_req_o) |-> $past(blk_req_o && blk_rsp_i && !blk_hit_i));

  // R12
  fault_clears_prot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && exc_o != 2'd0) |-> (prot_o == 3'b000));

  // R12
  ok_zero_syn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && exc_o == 2'd0) |-> (syn_o == 32'h0));

  // R8
  insn_syn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && exc_o == 2'd1) |-> ($countones(syn_o) == 1 && !syn_o[25]));

  // R7
  align_syn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && exc_o == 2'd3) |-> (syn_o == 32'h0));

  // R10
  far_update_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(far_o) |-> (done_o && exc_o[1]));

  // R12
  one_lookup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({blk_req_o, walk_req_o, done_o}));
endmodule

bind xlat_seq xlat_seq_chk #(.AW(AW)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .blk_req_o  (blk_req_o),
  .blk_rsp_i  (blk_rsp_i),
  .blk_hit_i  (blk_hit_i),
  .walk_req_o (walk_req_o),
  .done_o     (done_o),
  .prot_o     (prot_o),
  .exc_o      (exc_o),
  .syn_o      (syn_o),
  .far_o      (far_o)
);

// File: tb/test_xlat_seq.sv
`timescale 1ns/100ps
module test_xlat_seq;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         req_i = 1'b0;
  logic [31:0]  ea_i = '0;
  logic [1:0]   acc_i = '0;
  logic [2:0]   cls_i = '0;
  logic         user_i = 1'b0;
  logic         ir_en_i = 1'b1;
  logic         dr_en_i = 1'b1;
  logic [511:0] seg_regs_i;
  logic         blk_req_o, blk_fetch_o, walk_req_o, done_o;
  logic [31:0]  blk_ea_o, walk_ea_o, pa_o, syn_o, far_o;
  logic [23:0]  walk_vsid_o;
  logic         blk_rsp_i = 1'b0, blk_hit_i = 1'b0;
  logic [31:0]  blk_pa_i = '0;
  logic [2:0]   blk_prot_i = '0;
  logic         walk_rsp_i = 1'b0, walk_found_i = 1'b0;
  logic [1:0]   walk_pp_i = '0;
  logic [19:0]  walk_rpn_i = '0;
  logic [2:0]   prot_o;
  logic [1:0]   exc_o;

  always #2.5 clk_i = ~clk_i;

  logic [31:0] seg [16];
  always_comb for (int i = 0; i < 16; i++) seg_regs_i[i*32 +: 32] = seg[i];

  xlat_seq i_xlat_seq (.*);

  typedef struct {
    logic [31:0] pa;
    logic [2:0]  prot;
    logic [1:0]  exc;
    logic [31:0] syn;
    logic [31:0] far;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int n_chk = 0, n_fail = 0, n_issued = 0, n_done = 0;
  int blk_cnt = 0, walk_cnt = 0, walk_delay = 0, wwait = 0;
  logic [23:0] last_vsid = '0;
  logic [31:0] last_wea = '0;
  logic [31:0] far_m = '0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, expv);
    end
  endtask

  // stubs for matcher and walker
  always @(negedge clk_i) begin
    blk_rsp_i = blk_req_o && !blk_rsp_i;
    if (blk_rsp_i) blk_cnt++;
    if (walk_req_o && !walk_rsp_i) begin
      if (wwait >= walk_delay) begin
        walk_rsp_i = 1'b1;
        wwait = 0;
        walk_cnt++;
        last_vsid = walk_vsid_o;
        last_wea = walk_ea_o;
      end else begin
        wwait++;
      end
    end else begin
      walk_rsp_i = 1'b0;
    end
  end

  // monitor
  always @(negedge clk_i) begin
    if (rst_ni && done_o) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R12 unexpected done", {32'h0, pa_o}, 64'h0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(pa_o == e.pa && prot_o == e.prot && exc_o == e.exc && syn_o == e.syn && far_o == e.far,
            e.tag, {1'b0, prot_o, 2'b0, exc_o, 24'h0, syn_o[31:0]} ^ {32'h0, pa_o ^ far_o},
            {1'b0, e.prot, 2'b0, e.exc, 24'h0, e.syn} ^ {32'h0, e.pa ^ e.far});
      end
      n_done++;
    end
  end

  task automatic xreq(input logic [31:0] ea, input logic [1:0] acc, input logic [2:0] cls,
                      input bit user, input bit ir, input bit dr,
                      input bit bhit, input logic [31:0] bpa, input logic [2:0] bprot,
                      input bit wfound, input logic [1:0] pp, input logic [19:0] rpn,
                      input logic [31:0] xpa, input logic [2:0] xprot, input logic [1:0] xexc,
                      input logic [31:0] xsyn, input string tag, input bit poke = 1'b0);
    exp_t e;
    if (xexc[1]) far_m = ea;
    e.pa = xpa; e.prot = xprot; e.exc = xexc; e.syn = xsyn; e.far = far_m; e.tag = tag;
    exp_q.push_back(e);
    n_issued++;
    blk_hit_i = bhit; blk_pa_i = bpa; blk_prot_i = bprot;
    walk_found_i = wfound; walk_pp_i = pp; walk_rpn_i = rpn;
    @(negedge clk_i);
    ea_i = ea; acc_i = acc; cls_i = cls; user_i = user; ir_en_i = ir; dr_en_i = dr;
    req_i = 1'b1;
    @(negedge clk_i);
    req_i = 1'b0;
    if (poke) begin
      while (!walk_req_o) @(negedge clk_i);
      ea_i = 32'h0; acc_i = 2'd2; ir_en_i = 1'b0;
      req_i = 1'b1;
      @(negedge clk_i);
      req_i = 1'b0;
    end
    wait (n_done == n_issued);
    @(negedge clk_i);
  endtask

  initial begin
    #400_000;
    chk(1'b0, "watchdog R12", 64'h0, 64'h1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int b0, w0;
    for (int i = 0; i < 16; i++) seg[i] = '0;
    seg[5] = 32'h20AB_CDEF;  // Kp=1, Ks=0
    seg[6] = 32'h1000_0123;  // no-execute
    seg[7] = 32'h6000_0077;  // both keys 1
    seg[2] = 32'h87F0_0009;  // direct store, open unit
    seg[3] = 32'h8100_0000;  // direct store, unit 0x010
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!done_o && exc_o == 2'd0 && far_o == 32'h0 && !blk_req_o && !walk_req_o,
        "R12 reset state", {done_o, blk_req_o, walk_req_o, exc_o, far_o}, 64'h0);

    b0 = blk_cnt;
    xreq(32'h1234_5678, 2'd2, 3'd0, 0, 0, 1, 0, 0, 0, 0, 0, 0, 32'h1234_5678, 3'b111, 2'd0, 0, "R1 fetch bypass");
    xreq(32'h5000_0004, 2'd1, 3'd0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 32'h5000_0004, 3'b111, 2'd0, 0, "R1 data bypass");
    chk(blk_cnt == b0, "R1 no lookup on bypass", blk_cnt, b0);

    w0 = walk_cnt;
    xreq(32'h0000_2345, 2'd0, 3'd0, 0, 1, 1, 1, 32'h8000_1000, 3'b011, 0, 0, 0, 32'h8000_1000, 3'b011, 2'd0, 0, "R2 block hit read");
    xreq(32'h0000_2345, 2'd2, 3'd0, 0, 1, 1, 1, 32'h8000_1000, 3'b011, 0, 0, 0, 0, 0, 2'd1, 32'h0800_0000, "R2 R8 block fetch prot");
    xreq(32'h0000_4000, 2'd1, 3'd0, 0, 1, 1, 1, 32'h8000_1000, 3'b101, 0, 0, 0, 0, 0, 2'd2, 32'h0A00_0000, "R2 R9 R10 block write prot");
    xreq(32'h2000_0000, 2'd0, 3'd1, 0, 1, 1, 1, 32'h4000_0000, 3'b111, 0, 0, 0, 32'h4000_0000, 3'b111, 2'd0, 0, "R2 block beats direct store");
    chk(walk_cnt == w0, "R2 no walk on block hit", walk_cnt, w0);

    xreq(32'h5000_3ABC, 2'd0, 3'd0, 0, 1, 1, 0, 0, 0, 1, 2'd0, 20'h12345, 32'h1234_5ABC, 3'b101, 2'd0, 0, "R3 R11 walk read");
    chk(last_vsid == 24'hABCDEF, "R3 walk vsid", last_vsid, 24'hABCDEF);
    chk(last_wea == 32'h5000_3ABC, "R3 walk ea", last_wea, 32'h5000_3ABC);
    xreq(32'h5000_3ABC, 2'd1, 3'd0, 0, 1, 1, 0, 0, 0, 1, 2'd0, 20'h12345, 32'h1234_5ABC, 3'b111, 2'd0, 0, "R11 walk write keeps w");
    xreq(32'h5000_3ABC, 2'd0, 3'd0, 1, 1, 1, 0, 0, 0, 1, 2'd0, 20'h12345, 0, 0, 2'd2, 32'h0800_0000, "R4 user key1 pp0 read");
    xreq(32'h5000_5010, 2'd1, 3'd0, 1, 1, 1, 0, 0, 0, 1, 2'd1, 20'h12345, 0, 0, 2'd2, 32'h0A00_0000, "R4 R9 key1 pp1 write");
    xreq(32'h5000_6020, 2'd0, 3'd0, 1, 1, 1, 0, 0, 0, 1, 2'd3, 20'h00ABC, 32'h00AB_C020, 3'b101, 2'd0, 0, "R4 key1 pp3 read");
    xreq(32'h5000_7FFF, 2'd1, 3'd0, 1, 1, 1, 0, 0, 0, 1, 2'd2, 20'hFFFFF, 32'hFFFF_FFFF, 3'b111, 2'd0, 0, "R4 key1 pp2 write");
    xreq(32'h5000_8000, 2'd1, 3'd0, 0, 1, 1, 0, 0, 0, 1, 2'd3, 20'h1, 0, 0, 2'd2, 32'h0A00_0000, "R4 key0 pp3 write");
    xreq(32'h5000_9004, 2'd2, 3'd0, 0, 1, 1, 0, 0, 0, 1, 2'd3, 20'h00001, 32'h0000_1004, 3'b101, 2'd0, 0, "R4 R11 key0 pp3 fetch");
    xreq(32'h7000_0010, 2'd0, 3'd0, 0, 1, 1, 0, 0, 0, 1, 2'd0, 20'h1, 0, 0, 2'd2, 32'h0800_0000, "R4 supervisor key1");

    xreq(32'h0000_0100, 2'd0, 3'd0, 0, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 2'd2, 32'h4000_0000, "R9 no page read");
    xreq(32'h0000_0200, 2'd1, 3'd0, 0, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 2'd2, 32'h4200_0000, "R9 no page write");
    xreq(32'h0000_0300, 2'd2, 3'd0, 0, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 2'd1, 32'h4000_0000, "R8 R10 no page fetch");

    w0 = walk_cnt;
    xreq(32'h6000_0000, 2'd2, 3'd0, 0, 1, 1, 0, 0, 0, 1, 2'd0, 20'h1, 0, 0, 2'd1, 32'h1000_0000, "R5 R8 noexec fetch");
    chk(walk_cnt == w0, "R5 no walk on noexec fetch", walk_cnt, w0);
    xreq(32'h6000_1234, 2'd0, 3'd0, 0, 1, 1, 0, 0, 0, 1, 2'd0, 20'h22222, 32'h2222_2234, 3'b001, 2'd0, 0, "R5 noexec data read");

    w0 = walk_cnt;
    xreq(32'h2ABC_DEF0, 2'd2, 3'd0, 0, 1, 1, 0, 0, 0, 0, 0, 0, 32'h9ABC_DEF0, 3'b111, 2'd0, 0, "R6 open unit fetch");
    xreq(32'h2000_0008, 2'd1, 3'd1, 0, 1, 1, 0, 0, 0, 0, 0, 0, 32'h9000_0008, 3'b111, 2'd0, 0, "R6 open unit float write");
    xreq(32'h3000_0010, 2'd2, 3'd0, 0, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 2'd1, 32'h1000_0000, "R7 R8 dstore fetch");
    xreq(32'h3000_0020, 2'd0, 3'd0, 0, 1, 1, 0, 0, 0, 0, 0, 0, 32'h3000_0020, 3'b011, 2'd0, 0, "R7 dstore int");
    xreq(32'h3000_0030, 2'd1, 3'd3, 0, 1, 1, 0, 0, 0, 0, 0, 0, 32'h3000_0030, 3'b011, 2'd0, 0, "R7 dstore cache");
    xreq(32'h3000_0040, 2'd0, 3'd1, 0, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 2'd3, 0, "R7 R10 dstore float align");
    xreq(32'h3000_0050, 2'd1, 3'd2, 0, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 2'd2, 32'h0600_0000, "R9 dstore res write");
    xreq(32'h3000_0060, 2'd0, 3'd2, 0, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 2'd2, 32'h0400_0000, "R9 dstore res read");
    xreq(32'h3000_0070, 2'd0, 3'd4, 0, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 2'd2, 32'h0410_0000, "R9 dstore ext read");
    xreq(32'h3000_0080, 2'd1, 3'd4, 0, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 2'd2, 32'h0610_0000, "R9 dstore ext write");
    chk(walk_cnt == w0, "R6 R7 no walk in dstore", walk_cnt, w0);

    walk_delay = 3;
    xreq(32'h5000_0ABC, 2'd0, 3'd0, 0, 1, 1, 0, 0, 0, 1, 2'd0, 20'h33333, 32'h3333_3ABC, 3'b101, 2'd0, 0, "R12 busy request ignored", 1'b1);
    repeat (4) @(negedge clk_i);
    chk(n_done == n_issued, "R12 one done per request", n_done, n_issued);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule